// File: doc/BRIEF.md
# Configuration Base Register and Write-Once Identifier Slice

This block is a small slice of configuration space for a single device function. It holds a 64-bit memory base register and two 16-bit subsystem identifiers. Reads are combinational from a dword-aligned address. Writes take effect on the clock edge where the write strobe is high, and each byte enable gates its own byte.

The base register reports fixed type bits in its lowest nibble. These bits describe a non-prefetchable memory range that may be placed anywhere in a 64-bit address space. Firmware programs the two identifiers during boot. After its first accepted write, each identifier stays frozen until the platform reset is asserted. A separate function-level soft reset returns only the base register to its default value.

Top module: `cfg_bar_ids`

## Requirements
- R1: While the platform reset is asserted and after it is released, dword 10h reads 0000_0004h, dword 14h reads 0, and dword 2Ch reads 0.
- R2: Bits 63:4 of the base register are writable. Dword 10h holds bits 31:4 and dword 14h holds bits 63:32. The two dwords are written independently, and each byte enable (bit n gates wdata[8n+7:8n]) updates only its own byte.
- R3: Bits 3:0 of dword 10h always read 0100b: bit 0 = 0, bits 2:1 = 10b, bit 3 = 0. Write data on those bits has no effect.
- R4: Dword 2Ch holds the vendor identifier in bits 15:0 and the subsystem identifier in bits 31:16. Byte enables 0011b write only the vendor identifier, 1100b only the subsystem identifier, and 1111b both in the same cycle.
- R5: At dword 2Ch, a write with any other byte-enable pattern changes neither identifier and locks neither.
- R6: After an identifier has accepted a write, later writes to it are ignored.
- R7: The platform reset (active low, asynchronous) clears both identifiers and both locks.
- R8: The function-level soft reset (active high, synchronous) restores the base register to 0000_0000_0000_0004h. It does not change the identifiers or their locks.
- R9: Reads from any dword other than 10h, 14h and 2Ch return 0. Byte enables and address bits 1:0 have no effect on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| plat_rst_n | input | 1 | Platform reset, active low, asynchronous |
| func_rst | input | 1 | Function-level soft reset, active high, synchronous |
| reg_addr | input | 8 | Byte address; bits 1:0 are ignored |
| reg_be | input | 4 | Byte enables for writes |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |

## Verification
The bench sweeps all sixteen byte-enable patterns at the identifier dword. After each pattern it writes all four bytes again. This catches a design that accepts a straddling or single-byte write, and one that sets a lock on a dropped write, because the lock would show up as a value that refuses the second write. Every byte-enable pattern is also applied to both base dwords with all-zero and all-one data. This exposes a nibble that can be overwritten and a write that leaks into the other dword. A soft reset is pulsed on a fully programmed slice to catch a design that also clears the identifiers or unlocks them. All 64 dwords are read to catch a decode alias.

// File: rtl/cfg_bar_ids.sv
module cfg_bar_ids #(
  parameter logic [7:0]  BASE_LO_OFS = 8'h10,
  parameter logic [7:0]  BASE_HI_OFS = 8'h14,
  parameter logic [7:0]  IDS_OFS     = 8'h2C,
  parameter logic [3:0]  TYPE_BITS   = 4'b0100
) (
  input  logic        clk,
  input  logic        plat_rst_n,
  input  logic        func_rst,
  input  logic [7:0]  reg_addr,
  input  logic [3:0]  reg_be,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);

  localparam logic [5:0] DW_LO  = BASE_LO_OFS[7:2];
  localparam logic [5:0] DW_HI  = BASE_HI_OFS[7:2];
  localparam logic [5:0] DW_IDS = IDS_OFS[7:2];

  logic [27:0] base_lo;
  logic [31:0] base_hi;
  logic [15:0] vid, sid;
  logic        vid_lock, sid_lock;

  wire [5:0] dw     = reg_addr[7:2];
  wire       hit_lo = dw == DW_LO;
  wire       hit_hi = dw == DW_HI;
  wire       hit_id = dw == DW_IDS;

  wire be_lo16 = reg_be == 4'b0011;
  wire be_hi16 = reg_be == 4'b1100;
  wire be_all  = reg_be == 4'b1111;

  wire vid_wr = reg_we && hit_id && (be_lo16 || be_all) && !vid_lock;
  wire sid_wr = reg_we && hit_id && (be_hi16 || be_all) && !sid_lock;

  always_ff @(posedge clk or negedge plat_rst_n) begin
    if (!plat_rst_n) begin
      base_lo <= '0;
      base_hi <= '0;
    end else if (func_rst) begin
      base_lo <= '0;
      base_hi <= '0;
    end else if (reg_we) begin
      if (hit_lo) begin
        if (reg_be[0]) base_lo[3:0] <= reg_wdata[7:4];
        for (int b = 1; b < 4; b++)
          if (reg_be[b]) base_lo[8*b-4 +: 8] <= reg_wdata[8*b +: 8];
      end
      if (hit_hi) begin
        for (int b = 0; b < 4; b++)
          if (reg_be[b]) base_hi[8*b +: 8] <= reg_wdata[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge plat_rst_n) begin
    if (!plat_rst_n) begin
      vid      <= '0;
      sid      <= '0;
      vid_lock <= 1'b0;
      sid_lock <= 1'b0;
    end else begin
      if (vid_wr) begin
        vid      <= reg_wdata[15:0];
        vid_lock <= 1'b1;
      end
      if (sid_wr) begin
        sid      <= reg_wdata[31:16];
        sid_lock <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_lo)      reg_rdata = {base_lo, TYPE_BITS};
    else if (hit_hi) reg_rdata = base_hi;
    else if (hit_id) reg_rdata = {sid, vid};
  end

  AST_VID_FROZEN: assert property (@(posedge clk) disable iff (!plat_rst_n)
    vid_lock |=> $stable(vid) && vid_lock); // R6
  AST_SID_FROZEN: assert property (@(posedge clk) disable iff (!plat_rst_n)
    sid_lock |=> $stable(sid) && sid_lock); // R6
  AST_BAD_BE_DROPPED: assert property (@(posedge clk) disable iff (!plat_rst_n)
    (reg_we && hit_id && !(be_lo16 || be_hi16 || be_all))
      |=> $stable({vid, sid, vid_lock, sid_lock})); // R5
  AST_SOFT_RST_BASE: assert property (@(posedge clk) disable iff (!plat_rst_n)
    func_rst |=> (base_lo == '0) && (base_hi == '0)); // R8
  AST_SOFT_RST_KEEPS_IDS: assert property (@(posedge clk) disable iff (!plat_rst_n)
    (func_rst && !reg_we) |=> $stable({vid, sid, vid_lock, sid_lock})); // R8
  AST_FULL_WRITE_LOCKS: assert property (@(posedge clk) disable iff (!plat_rst_n)
    (reg_we && hit_id && be_all) |=> vid_lock && sid_lock); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !plat_rst_n |-> !vid_lock && !sid_lock && vid == '0 && sid == '0); // R7

endmodule

// File: tb/cfg_bar_ids_test.sv
module cfg_bar_ids_test;
  logic        clk = 0;
  logic        plat_rst_n = 0;
  logic        func_rst = 0;
  logic [7:0]  reg_addr = 0;
  logic [3:0]  reg_be = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  int total = 0, bad = 0;

  cfg_bar_ids uut (.*);

  always #5 clk = ~clk;

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] bmask(input logic [3:0] be);
    for (int b = 0; b < 4; b++) bmask[8*b +: 8] = be[b] ? 8'hFF : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    total++;
    if (reg_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_be = be; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0; reg_be = 0;
  endtask

  task automatic prst();
    @(negedge clk);
    plat_rst_n = 0;
    @(negedge clk);
    plat_rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] ev, es;
    logic [31:0] e, d;
    repeat (2) @(negedge clk);
    chk("R1", 8'h10, 32'h4);
    chk("R1", 8'h14, 32'h0);
    chk("R1", 8'h2C, 32'h0);
    plat_rst_n = 1;
    @(negedge clk);
    chk("R1", 8'h10, 32'h4);
    chk("R1", 8'h14, 32'h0);
    chk("R1", 8'h2C, 32'h0);

    // R4 R5 R6: identifier byte-enable sweep, then a full rewrite
    for (int be = 0; be < 16; be++) begin
      prst();
      d = {16'h5100 + 16'(be), 16'hA200 + 16'(be)};
      wr(8'h2C, 4'(be), d);
      ev = (be == 3 || be == 15) ? d[15:0] : 16'h0;
      es = (be == 12 || be == 15) ? d[31:16] : 16'h0;
      chk((be == 3 || be == 12 || be == 15) ? "R4" : "R5", 8'h2C, {es, ev});
      wr(8'h2C, 4'hF, 32'h1234_5678);
      if (!(be == 3 || be == 15)) ev = 16'h5678;
      if (!(be == 12 || be == 15)) es = 16'h1234;
      chk("R6", 8'h2C, {es, ev});
      wr(8'h2C, 4'hF, 32'hDEAD_BEEF);
      chk("R6", 8'h2C, {es, ev});
    end

    // R7: platform reset clears and unlocks
    prst();
    chk("R7", 8'h2C, 32'h0);
    wr(8'h2C, 4'h3, 32'h0000_1111);
    wr(8'h2C, 4'hC, 32'h2222_0000);
    chk("R7", 8'h2C, 32'h2222_1111);

    // R2 R3: base byte-enable sweep on both dwords
    for (int be = 0; be < 16; be++) begin
      for (int v = 0; v < 2; v++) begin
        d = v ? 32'hFFFF_FFFF : 32'h0;
        wr(8'h10, 4'hF, ~d);
        wr(8'h14, 4'hF, 32'h0F0F_0F0F);
        wr(8'h10, 4'(be), d);
        e = (((~d) & ~bmask(4'(be))) | (d & bmask(4'(be))));
        chk("R3", 8'h10, (e & 32'hFFFF_FFF0) | 32'h4);
        chk("R2", 8'h14, 32'h0F0F_0F0F);
        wr(8'h14, 4'(be), d);
        chk("R2", 8'h14, (32'h0F0F_0F0F & ~bmask(4'(be))) | (d & bmask(4'(be))));
        chk("R2", 8'h10, (e & 32'hFFFF_FFF0) | 32'h4);
      end
    end

    // R8: soft reset on programmed slice
    wr(8'h10, 4'hF, 32'hCAFE_F00D);
    wr(8'h14, 4'hF, 32'h8765_4321);
    @(negedge clk); func_rst = 1;
    @(negedge clk); func_rst = 0;
    chk("R8", 8'h10, 32'h4);
    chk("R8", 8'h14, 32'h0);
    chk("R8", 8'h2C, 32'h2222_1111);
    wr(8'h2C, 4'hF, 32'h9999_9999);
    chk("R8", 8'h2C, 32'h2222_1111);

    // R9: full read decode sweep
    wr(8'h10, 4'hF, 32'hAAAA_5555);
    wr(8'h14, 4'hF, 32'h3333_CCCC);
    for (int dwi = 0; dwi < 64; dwi++) begin
      reg_be = 4'(dwi);
      e = (dwi == 4) ? 32'hAAAA_5554 : (dwi == 5) ? 32'h3333_CCCC :
          (dwi == 11) ? 32'h2222_1111 : 32'h0;
      chk("R9", {6'(dwi), 2'(dwi)}, e);
    end
    reg_be = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule